// File: doc/BRIEF.md
# Dead-time edge delay generator

The block turns ideal edge events from a ramp timing source into gated PWM outputs. Each channel has two event strobes, `t1` and `t2`. Each channel also has a rising-edge delay and a falling-edge delay, and each edge can be bound to either strobe. When a bound strobe arrives, a down-counter starts. When the count expires, the output is set for the rise edge or cleared for the fall edge. One counter tick stands for 1.25 ns, so an 8-bit delay covers 0 to 318.75 ns.

Software reaches the block through a plain write bus, one configuration word per channel. Writes to any channel land in a shadow bank and do not touch the running timing. A write to the single commit channel copies the whole shadow bank into the active set at one clock edge, including the word being written in that same cycle. All channels therefore switch to new dead times together.

Top module: `dt_edge_gen`

## Requirements
- R1: After reset every `pwm_o` bit is low, every active delay is zero, rising edges follow `t1` and falling edges follow `t2`.
- R2: A configuration word holds the rise delay in bits [7:0] and the fall delay in bits [15:8]. Bit 16 picks the rise source and bit 17 picks the fall source, where 0 selects `t1` and 1 selects `t2`. A strobe that is not the selected source of an edge does not start that edge's delay.
- R3: A write to any channel other than `COMMIT_CH` changes only that channel's shadow word, and the active timing of all channels stays as it was.
- R4: A write to `COMMIT_CH` copies all shadow words into the active set at the write's clock edge, including its own new word. Events sampled at later edges use the new values.
- R5: With active rise delay d, `pwm_o` goes high at the clock edge d cycles after the edge that samples the selected rise strobe. When d is 0, it goes high at that sampling edge. d ranges from 0 to 255.
- R6: With active fall delay d, `pwm_o` goes low at the clock edge d cycles after the edge that samples the selected fall strobe. When d is 0, it goes low at that sampling edge. Without an expiring delay the output holds its level.
- R7: A new selected strobe arriving while that edge's delay is still pending restarts the count from the new strobe.
- R8: When the rise and fall delays of a channel expire at the same edge, the output goes low.
- R9: A pending count keeps the delay value captured at its start, even if a commit changes the active value meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per delay LSB |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | AW | Channel index of the write |
| wr_data_i | input | 2*DLY_W+2 | Configuration word (layout in R2) |
| t1_i | input | NUM_CH | Per-channel first edge event strobe |
| t2_i | input | NUM_CH | Per-channel second edge event strobe |
| pwm_o | output | NUM_CH | Gated outputs with dead times applied |

## Verification
The bench builds the block with four channels, 8-bit delays and channel 0 as the commit channel. With these values it can keep a write to a non-commit channel waiting in the shadow bank while traffic continues on other channels. Because one clock equals one LSB, the full delay range up to 255 can be reached within a short run. The bench also lines up a rise and a fall expiry on the same edge, which brings the priority rule and the in-flight commit case within reach.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
  typedef enum logic {SRC_T1 = 1'b0, SRC_T2 = 1'b1} dt_src_e;

  function automatic logic pick_evt(dt_src_e src, logic ev_a, logic ev_b);
    return (src == SRC_T2) ? ev_b : ev_a;
  endfunction
endpackage

// File: rtl/dt_shadow_regs.sv
`timescale 1ns/1ps
module dt_shadow_regs #(
  parameter int NUM_CH    = 4,
  parameter int DLY_W     = 8,
  parameter int COMMIT_CH = 0,
  parameter int AW        = 2,
  localparam int WORD_W   = 2*DLY_W + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [AW-1:0]                  wr_addr_i,
  input  logic [WORD_W-1:0]              wr_data_i,
  output logic [NUM_CH-1:0][WORD_W-1:0]  act_o
);
  // fall from t2, rise from t1, zero delays
  localparam logic [WORD_W-1:0] RST_WORD = {1'b1, 1'b0, {(2*DLY_W){1'b0}}};

  logic [NUM_CH-1:0][WORD_W-1:0] shd_q, shd_d, act_q;
  logic [NUM_CH-1:0]             wr_hit;
  logic                          commit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign wr_hit[i] = wr_en_i && (wr_addr_i == AW'(i));
  end

  assign commit = wr_hit[COMMIT_CH];

  always_comb begin
    shd_d = shd_q;
    for (int i = 0; i < NUM_CH; i++)
      if (wr_hit[i]) shd_d[i] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= {NUM_CH{RST_WORD}};
      act_q <= {NUM_CH{RST_WORD}};
    end else begin
      shd_q <= shd_d;
      if (commit) act_q <= shd_d;
    end
  end

  assign act_o = act_q;

  AST_HOLD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == AW'(COMMIT_CH)) |=> $stable(act_o)); // R3
  AST_COMMIT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(COMMIT_CH)) |=> act_o[COMMIT_CH] == $past(wr_data_i)); // R4
endmodule

// File: rtl/dt_edge_timer.sv
`timescale 1ns/1ps
module dt_edge_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] cnt_q;

  // zero delay fires on the sampling edge; otherwise fire when one tick remains
  assign fire_o = start_i ? (dly_i == '0) : (cnt_q == DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= dly_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - DLY_W'(1);
  end

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == $past(dly_i)); // R7
  AST_CNT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DLY_W'(1)); // R9
  AST_FIRE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !start_i) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/dt_channel.sv
`timescale 1ns/1ps
module dt_channel
  import dt_pkg::*;
#(
  parameter int DLY_W   = 8,
  localparam int WORD_W = 2*DLY_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              t1_i,
  input  logic              t2_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic              pwm_o
);
  // index 0: rise edge, index 1: fall edge
  logic [1:0]            start, fire;
  logic [1:0][DLY_W-1:0] dly;
  dt_src_e [1:0]         src;
  logic                  pwm_q;

  for (genvar e = 0; e < 2; e++) begin : g_edge
    assign dly[e]   = cfg_i[e*DLY_W +: DLY_W];
    assign src[e]   = dt_src_e'(cfg_i[2*DLY_W + e]);
    assign start[e] = pick_evt(src[e], t1_i, t2_i);

    dt_edge_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start[e]),
      .dly_i  (dly[e]),
      .fire_o (fire[e])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pwm_q <= 1'b0;
    else if (fire[1]) pwm_q <= 1'b0;
    else if (fire[0]) pwm_q <= 1'b1;
  end

  assign pwm_o = pwm_q;

  AST_FALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[1] |=> !pwm_o); // R8
  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire[0] && !fire[1]) |=> pwm_o); // R5
  AST_PWM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire == 2'b00) |=> $stable(pwm_o)); // R6
endmodule

// File: rtl/dt_edge_gen.sv
`timescale 1ns/1ps
module dt_edge_gen #(
  parameter int NUM_CH    = 4,
  parameter int DLY_W     = 8,
  parameter int COMMIT_CH = 0,
  localparam int AW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W   = 2*DLY_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [NUM_CH-1:0] t1_i,
  input  logic [NUM_CH-1:0] t2_i,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0][WORD_W-1:0] act;

  dt_shadow_regs #(
    .NUM_CH   (NUM_CH),
    .DLY_W    (DLY_W),
    .COMMIT_CH(COMMIT_CH),
    .AW       (AW)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .act_o    (act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dt_channel #(.DLY_W(DLY_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .t1_i  (t1_i[c]),
      .t2_i  (t2_i[c]),
      .cfg_i (act[c]),
      .pwm_o (pwm_o[c])
    );
  end

  AST_RESET_LOW: assert property (@(posedge clk_i) !rst_ni |=> pwm_o == '0); // R1
endmodule

// File: tb/sim_dt_edge_gen.sv
`timescale 1ns/1ps
module sim_dt_edge_gen;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int CMT = 0;
  localparam int AW  = 2;
  localparam int WW  = 2*DW + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [WW-1:0]  wr_data = '0;
  logic [NCH-1:0] t1 = '0;
  logic [NCH-1:0] t2 = '0;
  logic [NCH-1:0] pwm;

  dt_edge_gen #(.NUM_CH(NCH), .DLY_W(DW), .COMMIT_CH(CMT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .t1_i(t1), .t2_i(t2), .pwm_o(pwm)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int cyc; int ch; int val; string req;} exp_t;
  exp_t exp_q[$];
  exp_t e;
  int total = 0, bad = 0;
  logic [NCH-1:0] prev = '0;
  bit mon_on = 0, done = 0;
  string cur_req = "R1";

  // monitor: every output transition must match the head of the queue
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) begin
        if (pwm[c] !== prev[c]) begin
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL %s: unexpected edge ch=%0d actual val=%0d cyc=%0d expected none",
                     cur_req, c, pwm[c], cyc);
          end else begin
            e = exp_q.pop_front();
            if (e.ch != c || e.val != int'(pwm[c]) || e.cyc != cyc) begin
              bad++;
              $display("FAIL %s: actual ch=%0d val=%0d cyc=%0d expected ch=%0d val=%0d cyc=%0d",
                       e.req, c, pwm[c], cyc, e.ch, e.val, e.cyc);
            end
          end
        end
      end
      prev = pwm;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // all driver tasks enter and leave at a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, int rd, int fd, bit rs, bit fs);
    wr_en   = 1'b1;
    wr_addr = AW'(ch);
    wr_data = {fs, rs, DW'(fd), DW'(rd)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // val < 0: no output transition expected
  task automatic ev(int ch, bit use_t2, int dly, int val, string req);
    cur_req = req;
    if (use_t2) t2[ch] = 1'b1; else t1[ch] = 1'b1;
    if (val >= 0) exp_q.push_back('{cyc + 1 + dly, ch, val, req});
    @(negedge clk);
    t1 = '0;
    t2 = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL %s: watchdog expired actual=running expected=done", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(pwm == '0, "R1", int'(pwm), 0);
    rst_n = 1'b1;
    idle(1);
    chk(pwm == '0, "R1", int'(pwm), 0);
    prev = pwm;
    mon_on = 1;

    // R1 defaults: zero delay, rise on t1, fall on t2
    ev(0, 0, 0, 1, "R1"); idle(3);
    ev(0, 1, 0, 0, "R1"); idle(3);

    // R3 shadow-only write on channel 1
    wr(1, 5, 3, 0, 1);
    ev(1, 0, 0, 1, "R3"); idle(3);
    ev(1, 1, 0, 0, "R3"); idle(3);

    // R4 commit through channel 0 brings both words live
    wr(0, 2, 4, 0, 1);
    ev(1, 0, 5, 1, "R4"); idle(10);
    ev(1, 1, 3, 0, "R4"); idle(10);
    ev(0, 0, 2, 1, "R4"); idle(6);
    ev(0, 1, 4, 0, "R4"); idle(8);

    // R7 restart on a second strobe
    ev(1, 0, 0, -1, "R7"); idle(2);
    ev(1, 0, 5, 1, "R7");  idle(10);
    ev(1, 1, 3, 0, "R7");  idle(8);

    // R2 swapped sources on channel 3: rise from t2, fall from t1
    wr(3, 2, 6, 1, 0);
    wr(0, 2, 4, 0, 1);
    ev(3, 0, 0, -1, "R2"); idle(10);
    ev(3, 1, 2, 1, "R2");  idle(5);
    ev(3, 0, 6, 0, "R2");  idle(10);

    // R8 rise and fall expire on the same edge
    wr(2, 4, 1, 0, 1);
    wr(0, 2, 4, 0, 1);
    ev(2, 0, 4, 1, "R8"); idle(8);
    ev(2, 1, 1, 0, "R8"); idle(4);
    ev(2, 0, 0, -1, "R8"); idle(2);
    ev(2, 1, 0, -1, "R8"); idle(8);
    chk(pwm[2] == 1'b0, "R8", int'(pwm[2]), 0);

    // R9 commit while a count is pending
    wr(1, 9, 3, 0, 1);
    ev(1, 0, 5, 1, "R9");
    wr(0, 2, 4, 0, 1);
    idle(10);
    ev(1, 1, 3, 0, "R9"); idle(6);
    ev(1, 0, 9, 1, "R9"); idle(12);
    ev(1, 1, 3, 0, "R9"); idle(6);

    // R5 maximum delay, R6 zero fall delay
    wr(3, 255, 0, 1, 0);
    wr(0, 2, 4, 0, 1);
    ev(3, 1, 255, 1, "R5"); idle(260);
    ev(3, 0, 0, 0, "R6");   idle(5);

    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    chk(pwm == '0, "R6", int'(pwm), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule